// File: doc/BRIEF.md
# Shared Test/Programming Serial Pin Mode Switch

This block lets four serial pins serve two masters: a boundary-scan test access port and an in-system programming engine that has its own serial shift register. A level select input picks the owner. With the select high, the pins carry test mode select, test data in, test clock and test data out to and from the test port. With the select low, the same pins carry the programming mode control, serial data in, serial clock and serial data out to and from the programming engine. In programming mode the mode pin and the serial data pin together form the two control inputs the programming engine decodes.

The select is brought into a free-running system clock domain through a short synchronizer chain. Ownership of the pins follows the synchronized level. A high-to-low change of the synchronized select marks entry into programming mode. It raises a one-cycle entry pulse and sets a sticky flag that forces all user I/O to high impedance. The flag is only released once the select is high again and the programming engine reports idle. On the side that does not own the pins, the clock is held low so it sees no edges, and the control and data lines sit at fixed park values. The active-low test reset passes straight to the test port in either mode. The test port and the programming engine are outside this block and are reached through their own ports.

Top module: `pin_mode_switch`

## Requirements
- R1: While rst_n is low and at release, the test side owns the pins (tap_tck follows pin_sclk, prg_sclk is 0), and io_hiz and prg_entry are 0.
- R2: When the test side owns the pins, tap_tms = pin_mode, tap_tdi = pin_sdi, tap_tck = pin_sclk and pin_sdo = tap_tdo.
- R3: When the programming side owns the pins, prg_mode = pin_mode, prg_sdi = pin_sdi, prg_sclk = pin_sclk and pin_sdo = prg_sdo, so both control inputs reach the programming engine.
- R4: The side that does not own the pins sees its clock held at 0. A parked test side sees tap_tms = 1 and tap_tdi = 1. A parked programming side sees prg_mode = 0 and prg_sdi = 0.
- R5: Ownership follows sel_pin (1 = test side, 0 = programming side) after SYNC_STAGES rising clk edges (2 by default). The old owner is still routed after the first edge that follows a change.
- R6: A high-to-low change of the synchronized select produces prg_entry high for exactly one cycle, registered on the edge after ownership moves to the programming side (the third edge after the change by default).
- R7: io_hiz rises on the same edge as prg_entry.
- R8: io_hiz stays 1 while the select is low, and also while the select is high with prg_idle low. It clears on the first edge at which the test side owns the pins and prg_idle is 1.
- R9: A low-to-high change of the select never pulses prg_entry and never sets io_hiz.
- R10: The synchronizer resets to the test-side level, so a select held low through reset release counts as a falling edge. prg_entry and io_hiz then rise on the third edge after release.
- R11: tap_trst_n equals trst_n in both ownership states.
- R12: A select low for a single clk period that spans one rising edge is still recognised as entry. Ownership returns to the test side one cycle later, and io_hiz clears on the following edge when prg_idle is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pin | input | 1 | Owner select: 1 test side, 0 programming side |
| trst_n | input | 1 | Active-low test reset pin |
| pin_mode | input | 1 | Shared mode / test mode select pin |
| pin_sdi | input | 1 | Shared serial data in pin |
| pin_sclk | input | 1 | Shared serial clock pin |
| pin_sdo | output | 1 | Shared serial data out pin |
| tap_tms | output | 1 | Test mode select to test port |
| tap_tdi | output | 1 | Test data in to test port |
| tap_tck | output | 1 | Test clock to test port |
| tap_trst_n | output | 1 | Test reset to test port |
| tap_tdo | input | 1 | Test data out from test port |
| prg_mode | output | 1 | Mode control to programming engine |
| prg_sdi | output | 1 | Serial data / second control to programming engine |
| prg_sclk | output | 1 | Shift clock to programming engine |
| prg_sdo | input | 1 | Readback data from programming engine |
| prg_idle | input | 1 | Programming engine reports idle |
| prg_entry | output | 1 | One-cycle pulse on entry into programming mode |
| io_hiz | output | 1 | Force all user I/O to high impedance |

## Verification
The hardest case to reach is a select that returns high while the programming engine is still busy. The high-impedance flag must then outlive the ownership change and clear on one exact edge. The stimulus enters programming mode with prg_idle low, raises the select and waits past the synchronizer delay. It confirms the test side already owns the pins while io_hiz is still set, then raises prg_idle and expects the clear on the next edge. The single-period select pulse and the select held low through reset release are driven as separate scenarios, because both produce edges that only the synchronizer's reset value and depth decide.

// File: rtl/pms_pkg.sv
package pms_pkg;

    // Owner of the shared serial pins; the value equals the select level.
    typedef enum logic {
        OWNER_PRG = 1'b0,
        OWNER_TAP = 1'b1
    } owner_e;

    // Registered state of the mode controller.
    typedef struct packed {
        logic prev_tap;   // synchronized select seen on the previous cycle
        logic hiz;        // user I/O forced to high impedance
        logic entry;      // programming-entry pulse
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{prev_tap: 1'b1, hiz: 1'b0, entry: 1'b0};

endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_in;
        for (int i = 1; i <= LAST; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_out = chain_q[LAST];

endmodule

// File: rtl/pms_mode_ctl.sv
module pms_mode_ctl
    import pms_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel_sync,
    input  logic   prg_idle,
    output owner_e owner,
    output logic   prg_entry,
    output logic   io_hiz
);
    ctl_state_t st_d, st_q;
    logic       fall_det;
    logic       release_ok;

    always_comb begin
        st_d       = st_q;
        fall_det   = st_q.prev_tap & ~sel_sync;
        release_ok = sel_sync & prg_idle;
        st_d.prev_tap = sel_sync;
        st_d.entry    = fall_det;
        if (st_q.hiz) st_d.hiz = ~release_ok | fall_det;
        else          st_d.hiz = fall_det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTL_RESET;
        else        st_q <= st_d;
    end

    assign owner     = owner_e'(sel_sync);
    assign prg_entry = st_q.entry;
    assign io_hiz    = st_q.hiz;

    // R7: the high-Z flag only rises together with an entry pulse
    assert_hiz_with_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_hiz) |-> prg_entry);

    // R8: the high-Z flag only drops after test ownership with idle engine
    assert_hiz_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_hiz) |-> $past(sel_sync && prg_idle));

    // R6: entry is a single-cycle pulse
    assert_entry_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prg_entry |=> !prg_entry);

    // R9: an entry pulse always follows a cycle of programming ownership
    assert_entry_after_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prg_entry |-> $past(!sel_sync));

endmodule

// File: rtl/pms_pin_mux.sv
module pms_pin_mux
    import pms_pkg::*;
#(
    parameter logic PARK_TMS  = 1'b1,
    parameter logic PARK_TDI  = 1'b1,
    parameter logic PARK_MODE = 1'b0,
    parameter logic PARK_SDI  = 1'b0
) (
    input  owner_e owner,
    input  logic   pin_mode,
    input  logic   pin_sdi,
    input  logic   pin_sclk,
    output logic   pin_sdo,
    output logic   tap_tms,
    output logic   tap_tdi,
    output logic   tap_tck,
    input  logic   tap_tdo,
    output logic   prg_mode,
    output logic   prg_sdi,
    output logic   prg_sclk,
    input  logic   prg_sdo
);
    logic to_tap;

    always_comb begin
        to_tap = (owner == OWNER_TAP);
        // test side: live when owning, parked otherwise (clock held low)
        tap_tms  = to_tap ? pin_mode : PARK_TMS;
        tap_tdi  = to_tap ? pin_sdi  : PARK_TDI;
        tap_tck  = to_tap & pin_sclk;
        // programming side: mode and serial data are both control inputs
        prg_mode = to_tap ? PARK_MODE : pin_mode;
        prg_sdi  = to_tap ? PARK_SDI  : pin_sdi;
        prg_sclk = ~to_tap & pin_sclk;
        // shared serial output
        pin_sdo  = to_tap ? tap_tdo : prg_sdo;
    end

endmodule

// File: rtl/pin_mode_switch.sv
module pin_mode_switch
    import pms_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_pin,
    input  logic trst_n,
    input  logic pin_mode,
    input  logic pin_sdi,
    input  logic pin_sclk,
    output logic pin_sdo,
    output logic tap_tms,
    output logic tap_tdi,
    output logic tap_tck,
    output logic tap_trst_n,
    input  logic tap_tdo,
    output logic prg_mode,
    output logic prg_sdi,
    output logic prg_sclk,
    input  logic prg_sdo,
    input  logic prg_idle,
    output logic prg_entry,
    output logic io_hiz
);
    logic   sel_sync;
    owner_e owner;

    pms_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (sel_pin),
        .q_out (sel_sync)
    );

    pms_mode_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_sync  (sel_sync),
        .prg_idle  (prg_idle),
        .owner     (owner),
        .prg_entry (prg_entry),
        .io_hiz    (io_hiz)
    );

    pms_pin_mux u_mux (
        .owner    (owner),
        .pin_mode (pin_mode),
        .pin_sdi  (pin_sdi),
        .pin_sclk (pin_sclk),
        .pin_sdo  (pin_sdo),
        .tap_tms  (tap_tms),
        .tap_tdi  (tap_tdi),
        .tap_tck  (tap_tck),
        .tap_tdo  (tap_tdo),
        .prg_mode (prg_mode),
        .prg_sdi  (prg_sdi),
        .prg_sclk (prg_sclk),
        .prg_sdo  (prg_sdo)
    );

    assign tap_trst_n = trst_n;

    // R4: never both sides clocked at once
    assert_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tap_tck, prg_sclk}));

    // R3: an entry pulse is seen while the programming side is or was just clocked
    assert_entry_prg_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prg_entry |-> $past(owner == OWNER_PRG));

endmodule

// File: tb/tb_pin_mode_switch.sv
module tb_pin_mode_switch;

    logic clk = 1'b0;
    logic rst_n, sel_pin, trst_n, pin_mode, pin_sdi, pin_sclk;
    logic tap_tdo, prg_sdo, prg_idle;
    logic pin_sdo, tap_tms, tap_tdi, tap_tck, tap_trst_n;
    logic prg_mode, prg_sdi, prg_sclk, prg_entry, io_hiz;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pin_mode_switch dut (
        .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .trst_n(trst_n),
        .pin_mode(pin_mode), .pin_sdi(pin_sdi), .pin_sclk(pin_sclk),
        .pin_sdo(pin_sdo), .tap_tms(tap_tms), .tap_tdi(tap_tdi),
        .tap_tck(tap_tck), .tap_trst_n(tap_trst_n), .tap_tdo(tap_tdo),
        .prg_mode(prg_mode), .prg_sdi(prg_sdi), .prg_sclk(prg_sclk),
        .prg_sdo(prg_sdo), .prg_idle(prg_idle), .prg_entry(prg_entry),
        .io_hiz(io_hiz)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic t_reset;   // R1
        rst_n = 1'b0; sel_pin = 1'b1; pin_sclk = 1'b1;
        step(2);
        chk("R1 tck in reset", tap_tck, 1'b1);
        chk("R1 prg clk in reset", prg_sclk, 1'b0);
        chk("R1 hiz in reset", io_hiz, 1'b0);
        chk("R1 entry in reset", prg_entry, 1'b0);
        rst_n = 1'b1;
        step(3);
        chk("R1 hiz after release", io_hiz, 1'b0);
        chk("R1 entry after release", prg_entry, 1'b0);
    endtask

    task automatic t_test_route;  // R2, R4
        for (int i = 0; i < 8; i++) begin
            {pin_mode, pin_sdi, pin_sclk} = 3'(i);
            tap_tdo = pin_mode ^ pin_sdi;
            prg_sdo = ~tap_tdo;
            #1;
            chk("R2 tms", tap_tms, pin_mode);
            chk("R2 tdi", tap_tdi, pin_sdi);
            chk("R2 tck", tap_tck, pin_sclk);
            chk("R2 sdo", pin_sdo, tap_tdo);
            chk("R4 prg clk parked", prg_sclk, 1'b0);
            chk("R4 prg mode parked", prg_mode, 1'b0);
            chk("R4 prg sdi parked", prg_sdi, 1'b0);
        end
    endtask

    task automatic t_entry;  // R5, R6, R7
        prg_idle = 1'b0; pin_sclk = 1'b1;
        sel_pin = 1'b0;
        step(1);
        chk("R5 old owner after one edge", tap_tck, 1'b1);
        chk("R6 no early entry", prg_entry, 1'b0);
        step(1);
        chk("R5 prg owns after two edges", prg_sclk, 1'b1);
        chk("R5 test clk held", tap_tck, 1'b0);
        chk("R6 entry not yet", prg_entry, 1'b0);
        chk("R7 hiz not yet", io_hiz, 1'b0);
        step(1);
        chk("R6 entry pulse", prg_entry, 1'b1);
        chk("R7 hiz with entry", io_hiz, 1'b1);
        step(1);
        chk("R6 pulse one cycle", prg_entry, 1'b0);
        chk("R8 hiz holds", io_hiz, 1'b1);
    endtask

    task automatic t_prog_route;  // R3, R4
        for (int i = 0; i < 8; i++) begin
            {pin_mode, pin_sdi, pin_sclk} = 3'(7 - i);
            prg_sdo = pin_sdi ^ pin_sclk;
            tap_tdo = ~prg_sdo;
            #1;
            chk("R3 mode", prg_mode, pin_mode);
            chk("R3 sdi", prg_sdi, pin_sdi);
            chk("R3 sclk", prg_sclk, pin_sclk);
            chk("R3 sdo", pin_sdo, prg_sdo);
            chk("R4 tck parked", tap_tck, 1'b0);
            chk("R4 tms parked", tap_tms, 1'b1);
            chk("R4 tdi parked", tap_tdi, 1'b1);
        end
    endtask

    task automatic t_hiz_hold;  // R8
        prg_idle = 1'b1;
        step(4);
        chk("R8 hiz holds while low and idle", io_hiz, 1'b1);
        prg_idle = 1'b0;
        sel_pin = 1'b1; pin_sclk = 1'b1;
        step(4);
        chk("R8 test side owns again", tap_tck, 1'b1);
        chk("R8 hiz holds while busy", io_hiz, 1'b1);
        chk("R9 no entry on rise", prg_entry, 1'b0);
        prg_idle = 1'b1;
        step(1);
        chk("R8 hiz clears on idle", io_hiz, 1'b0);
    endtask

    task automatic t_rise_no_entry;  // R9
        sel_pin = 1'b0;
        step(5);
        sel_pin = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step(1);
            chk("R9 no entry after rise", prg_entry, 1'b0);
        end
        chk("R9 hiz cleared, not set", io_hiz, 1'b0);
        step(2);
        chk("R9 hiz stays clear", io_hiz, 1'b0);
    endtask

    task automatic t_short_pulse;  // R12
        prg_idle = 1'b1;
        sel_pin = 1'b0;
        step(1);
        sel_pin = 1'b1;
        step(1);
        chk("R12 no entry yet", prg_entry, 1'b0);
        step(1);
        chk("R12 entry from short pulse", prg_entry, 1'b1);
        chk("R12 hiz from short pulse", io_hiz, 1'b1);
        step(1);
        chk("R12 hiz clears", io_hiz, 1'b0);
        chk("R12 entry ends", prg_entry, 1'b0);
    endtask

    task automatic t_low_reset;  // R10
        rst_n = 1'b0; sel_pin = 1'b0; pin_sclk = 1'b1;
        step(2);
        chk("R10 test side in reset", tap_tck, 1'b1);
        rst_n = 1'b1;
        step(1);
        chk("R10 no entry edge 1", prg_entry, 1'b0);
        step(1);
        chk("R10 prg owns edge 2", prg_sclk, 1'b1);
        chk("R10 no entry edge 2", prg_entry, 1'b0);
        step(1);
        chk("R10 entry edge 3", prg_entry, 1'b1);
        chk("R10 hiz edge 3", io_hiz, 1'b1);
    endtask

    task automatic t_trst;  // R11
        for (int v = 0; v < 2; v++) begin
            trst_n = 1'(v);
            #1;
            chk("R11 trst follows", tap_trst_n, 1'(v));
        end
        sel_pin = 1'b1;
        step(3);
        for (int v = 1; v >= 0; v--) begin
            trst_n = 1'(v);
            #1;
            chk("R11 trst follows test side", tap_trst_n, 1'(v));
        end
        trst_n = 1'b1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sel_pin = 1'b1; trst_n = 1'b1;
        pin_mode = 1'b0; pin_sdi = 1'b0; pin_sclk = 1'b0;
        tap_tdo = 1'b0; prg_sdo = 1'b0; prg_idle = 1'b0;
        t_reset();
        t_test_route();
        t_entry();
        t_prog_route();
        t_hiz_hold();
        t_rise_no_entry();
        t_short_pulse();
        t_low_reset();
        t_trst();
        done = 1'b1;
        report();
        $finish;
    end

endmodule